// File: doc/BRIEF.md
# Dual-Modulus Programmable Loop Divider

This block divides a VCO-rate clock by a programmable 14-bit code N and marks the end of every division cycle for a phase comparator. It uses the pulse-swallow structure. A prescaler divides by 31 or by 32. A swallow counter and a main counter, both clocked by the prescaler's terminal count, choose the prescaler ratio. The code is split into a main count M = N / 31 and a swallow count A = N mod 31. The prescaler runs at 32 for the first A sub-cycles and at 31 for the remaining M - A sub-cycles, so that one cycle lasts 31·M + A = N input clocks.

The output `div_out` is high for most of the cycle. It drops low for exactly one input clock, the clock just before the counters reload, and its falling edge is the timing event. A new code is taken only at a reload, so a code written in the middle of a cycle never shortens or stretches the running cycle. The `clear` input forces a reload at the next edge. Codes from 961 upward always divide exactly. Below 961, a code divides exactly only when A ≤ M and M ≥ 1. Other codes are clamped to a fixed period and flagged on `code_invalid`. All pins are plain control and status pins: no data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `dual_mod_ndiv`

## Requirements
- R1: With a constant code N that divides exactly, `div_out` is low for exactly one clock in every N consecutive clocks.
- R2: The low clock of `div_out` is the last clock of a cycle. The reload happens at the edge that ends it, and `div_out` stays high for at least the next 30 clocks unless `clear` is raised.
- R3: `div_code` is sampled only at the reload edge. A change in the middle of a cycle first affects the cycle that follows the next reload.
- R4: When `clear` is high at a rising edge, the counters reload at that edge with the current `div_code`. `div_out` is low in every clock while `clear` is high, and the new cycle counts from that edge.
- R5: During reset `div_out` is low and `code_invalid` is 0. The first rising edge after reset is released performs a reload.
- R6: Every code from 961 to 16383 divides exactly, and `code_invalid` is 0 for its cycles.
- R7: A code below 961 with M ≥ 1 and A ≤ M (for example 62, 95 or 960) divides exactly, with `code_invalid` at 0.
- R8: A code with M ≥ 1 and A > M runs with the swallow count clamped to M. Its period is 32·M clocks and `code_invalid` is 1.
- R9: A code below 31 (M = 0) runs with a period of 31 clocks and `code_invalid` at 1.
- R10: `code_invalid` changes only at reload edges and describes the code sampled at the most recent reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 14 | Divide code N, sampled at reload |
| clear | input | 1 | Forces a reload at the next rising edge |
| div_out | output | 1 | Low for the single clock that precedes a reload |
| code_invalid | output | 1 | High while the running cycle uses a clamped code |

## Verification
The bench builds the block with its default parameters: a 14-bit code and a 31/32 prescaler. This brings the whole code range within reach, including 961, the largest code 16383, sparse codes below 961 that still divide exactly, and both clamp cases. Because the prescaler base stays at 31, the swallow and main splits seen in the bench match those of the intended 961 boundary. The bench also changes the code in the middle of a cycle and applies single-clock and held clear pulses. Each of these is compared clock by clock against an integer period model.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
  // Default geometry of the loop divider.
  localparam int unsigned NDIV_CODE_W  = 14;
  localparam int unsigned NDIV_PRE_LOW = 31;

  // Ratio chosen for the next prescaler sub-cycle.
  typedef enum logic {
    PRE_DIV_LO = 1'b0,  // divide by PRE_LOW
    PRE_DIV_HI = 1'b1   // divide by PRE_LOW + 1
  } pre_mod_e;
endpackage

// File: rtl/ndiv_code_split.sv
// Splits a divide code into main and swallow counts and clamps illegal pairs.
module ndiv_code_split #(
  parameter int unsigned CODE_W  = 14,
  parameter int unsigned PRE_LOW = 31,
  localparam int unsigned MW = $clog2((2**CODE_W - 1) / PRE_LOW + 1),
  localparam int unsigned AW = $clog2(PRE_LOW)
) (
  input  logic [CODE_W-1:0] code,
  output logic [MW-1:0]     m_val,
  output logic [AW-1:0]     a_val,
  output logic              bad
);
  localparam logic [CODE_W-1:0] BASE = CODE_W'(PRE_LOW);

  logic [CODE_W-1:0] quo;
  logic [CODE_W-1:0] rem;
  logic              unused_hi;

  assign quo = code / BASE;
  assign rem = code % BASE;
  assign unused_hi = ^{quo[CODE_W-1:MW], rem[CODE_W-1:AW]};

  always_comb begin
    m_val = quo[MW-1:0];
    a_val = rem[AW-1:0];
    bad   = 1'b0;
    if (quo == '0) begin
      // No main count: fall back to a single low-ratio sub-cycle.
      m_val = MW'(1);
      a_val = '0;
      bad   = 1'b1;
    end else if (rem > quo) begin
      // Swallow count cannot exceed main count: clamp it.
      a_val = quo[AW-1:0];
      bad   = 1'b1;
    end
  end
endmodule

// File: rtl/ndiv_prescaler.sv
// Dual-ratio prescaler: counts PRE_LOW or PRE_LOW+1 input clocks per sub-cycle.
module ndiv_prescaler
  import ndiv_pkg::*;
#(
  parameter int unsigned PRE_LOW = 31,
  localparam int unsigned CW = $clog2(PRE_LOW + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pre_mod_e mod_next,
  output logic     tc
);
  logic [CW-1:0] pre_cnt;
  logic [CW-1:0] start_val;

  assign start_val = (mod_next == PRE_DIV_HI) ? CW'(PRE_LOW) : CW'(PRE_LOW - 1);
  assign tc        = (pre_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_cnt <= '0;
    else if (load || tc) pre_cnt <= start_val;
    else                pre_cnt <= pre_cnt - CW'(1);
  end

  // Every sub-cycle restarts at one of the two ratios (R1).
  assert_subcycle_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (pre_cnt >= CW'(PRE_LOW - 1)));
endmodule

// File: rtl/ndiv_chain.sv
// Swallow and main counters clocked by the prescaler terminal count.
module ndiv_chain
  import ndiv_pkg::*;
#(
  parameter int unsigned CODE_W  = 14,
  parameter int unsigned PRE_LOW = 31,
  localparam int unsigned MW = $clog2((2**CODE_W - 1) / PRE_LOW + 1),
  localparam int unsigned AW = $clog2(PRE_LOW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tc,
  input  logic          reload,
  input  logic [MW-1:0] m_new,
  input  logic [AW-1:0] a_new,
  output logic          terminal,
  output pre_mod_e      mod_next
);
  logic [MW-1:0] m_rem;
  logic [AW-1:0] a_rem;

  assign terminal = tc && (m_rem == MW'(1));

  always_comb begin
    if (reload) mod_next = (a_new != '0)        ? PRE_DIV_HI : PRE_DIV_LO;
    else        mod_next = (a_rem > AW'(1))     ? PRE_DIV_HI : PRE_DIV_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem <= MW'(1);
      a_rem <= '0;
    end else if (reload) begin
      m_rem <= m_new;
      a_rem <= a_new;
    end else if (tc) begin
      m_rem <= m_rem - MW'(1);
      if (a_rem != '0) a_rem <= a_rem - AW'(1);
    end
  end

  // Swallowed sub-cycles never outnumber the remaining ones (R8).
  assert_swallow_le_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a_rem <= AW'(m_rem > MW'(PRE_LOW) ? PRE_LOW : m_rem));
  // The main count is reloaded before it can run out (R1).
  assert_main_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_rem != '0);
endmodule

// File: rtl/dual_mod_ndiv.sv
// Programmable pulse-swallow loop divider.
module dual_mod_ndiv
  import ndiv_pkg::*;
#(
  parameter int unsigned CODE_W  = NDIV_CODE_W,
  parameter int unsigned PRE_LOW = NDIV_PRE_LOW,
  localparam int unsigned MW = $clog2((2**CODE_W - 1) / PRE_LOW + 1),
  localparam int unsigned AW = $clog2(PRE_LOW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              clear,
  output logic              div_out,
  output logic              code_invalid
);
  logic [MW-1:0] m_new;
  logic [AW-1:0] a_new;
  logic          split_bad;
  logic          tc;
  logic          terminal;
  logic          reload;
  pre_mod_e      mod_next;

  ndiv_code_split #(.CODE_W(CODE_W), .PRE_LOW(PRE_LOW)) u_split (
    .code  (div_code),
    .m_val (m_new),
    .a_val (a_new),
    .bad   (split_bad)
  );

  ndiv_prescaler #(.PRE_LOW(PRE_LOW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .mod_next (mod_next),
    .tc       (tc)
  );

  ndiv_chain #(.CODE_W(CODE_W), .PRE_LOW(PRE_LOW)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc       (tc),
    .reload   (reload),
    .m_new    (m_new),
    .a_new    (a_new),
    .terminal (terminal),
    .mod_next (mod_next)
  );

  assign reload  = terminal || clear;
  assign div_out = !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_invalid <= 1'b0;
    else if (reload) code_invalid <= split_bad;
  end

  // A fresh cycle is never shorter than one prescaler sub-cycle (R2).
  assert_high_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (div_out || clear));
  // After a clear edge the chain restarts rather than ending at once (R4).
  assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !terminal);
  // The validity flag only moves at reload edges (R10).
  assert_flag_at_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(code_invalid));
endmodule

// File: tb/dual_mod_ndiv_tb.sv
module dual_mod_ndiv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] div_code = 14'd961;
  logic        clear = 1'b0;
  logic        div_out;
  logic        code_invalid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R5";

  // Behavioural model: an integer period and a position within it.
  int per = 1;
  int pos = 0;
  bit m_flag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_mod_ndiv u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_code     (div_code),
    .clear        (clear),
    .div_out      (div_out),
    .code_invalid (code_invalid)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      per = 1; pos = 0; m_flag = 1'b0;
    end else if (clear || pos == per - 1) begin
      int m, a;
      m = int'(div_code) / 31;
      a = int'(div_code) % 31;
      if (m == 0)     begin per = 31;     m_flag = 1'b1; end
      else if (a > m) begin per = 32 * m; m_flag = 1'b1; end
      else            begin per = int'(div_code); m_flag = 1'b0; end
      pos = 0;
    end else begin
      pos = pos + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_out;
      exp_out = !(clear || pos == per - 1);
      total++;
      if (div_out !== exp_out) begin
        bad++;
        $display("FAIL %s div_out=%0b expected=%0b code=%0d cycle=%0d",
                 tag, div_out, exp_out, div_code, cyc);
      end
      total++;
      if (code_invalid !== m_flag) begin
        bad++;
        $display("FAIL %s code_invalid=%0b expected=%0b code=%0d cycle=%0d",
                 tag, code_invalid, m_flag, div_code, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int code, input int n, input string t);
    @(negedge clk); #1;
    div_code = 14'(code);
    tag = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear(input int len);
    @(negedge clk); #1;
    clear = 1'b1;
    tag = "R4";
    repeat (len) @(negedge clk);
    #1 clear = 1'b0;
  endtask

  initial begin
    // R5: reset state at the ports.
    repeat (3) @(negedge clk);
    total++;
    if (div_out !== 1'b0 || code_invalid !== 1'b0) begin
      bad++;
      $display("FAIL R5 div_out=%0b code_invalid=%0b expected=0 0", div_out, code_invalid);
    end
    #1 rst_n = 1'b1;
    tag = "R5";
    repeat (2) @(negedge clk);

    run(961,   3 * 961 + 5,      "R1 R2 R6");
    run(16383, 2 * 16383 + 40,   "R1 R6");
    run(962,   3 * 962 + 3,      "R1 R6");
    run(1234,  3 * 1234,         "R1 R6");
    run(95,    8 * 95,           "R7");
    run(62,    8 * 62,           "R7");
    run(960,   4 * 960,          "R7");
    run(200,   8 * 192,          "R8 R10");
    run(100,   8 * 96,           "R8 R10");
    run(20,    8 * 31,           "R9 R10");
    run(0,     8 * 31,           "R9 R10");
    run(1500,  3 * 1500,         "R10 R6");
    // R3: change the code in the middle of a running cycle.
    run(2000,  2000 + 500,       "R3");
    run(1111,  3 * 1111 + 200,   "R3");
    // R4: single-clock and held clear pulses.
    run(1000,  300,              "R1");
    pulse_clear(1);
    run(1000,  300,              "R4");
    pulse_clear(3);
    run(1000,  2500,             "R4");
    pulse_clear(1);
    run(97,    4 * 96,           "R4 R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule